// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

The block watches a bank of external interrupt request pins, eight by default. Each pin first passes through a two-flop synchroniser. The synchronised sample is then compared with the sample from the previous cycle, which finds edges. A 2-bit code per pin selects what counts as an event: a low level, a falling edge, a rising edge, or either edge. A detected event sets that pin's bit in a status register. Each status bit drives an active-high level interrupt output toward a parent interrupt controller. The parent controller handles priority and masking.

Software uses a simple 32-bit register port. It programs the sense codes at offset 0x14 and reads the latched events at offset 0x10. To acknowledge a pin, software writes the status register back with that pin's bit at zero. Writing a one to a status bit leaves it unchanged. Reads are combinational in the cycle of the request. Writes take effect at the next clock edge. The port has no back-pressure: every request completes in its own cycle.

Top module: `ext_irq_sense_unit`

## Requirements
- R1: After reset every sense code is 0, every status bit is 0 and every `irq_o` bit is low.
- R2: A write to offset 0x14 stores the sense codes. Pin n uses bits [2n+1:2n] (bits 15:0 by default). A read of 0x14 returns the codes, and the bits above them read as zero.
- R3: With code 0 (low level), a status bit is set while the pin is low. A clear write does not clear it while the pin stays low. Once the pin is high, a clear write clears it.
- R4: With code 1, only a high-to-low transition of the pin sets the status bit. A rising transition does not.
- R5: With code 2, only a low-to-high transition sets the status bit. A falling transition does not.
- R6: With code 3, both transitions set the status bit.
- R7: The status register at offset 0x10 has bit n for pin n, and its upper bits read as zero. A write clears each bit written as 0. A bit written as 1 keeps its value, so a write cannot set a bit.
- R8: If an event and a clearing write to the same bit fall in the same cycle, the bit stays set.
- R9: `irq_o[n]` is an active-high level that equals status bit n.
- R10: A read of any offset other than 0x10 and 0x14 returns zero. A write to such an offset changes nothing.
- R11: A pin change is seen in status and on `irq_o` after the third rising clock edge following the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt request pins |
| bus_en | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read request, zero otherwise |
| irq_o | output | NUM_PINS | Active-high level interrupt per pin to the parent controller |

## Verification
Two things can act on the same status bit in one cycle: a detected pin event, which sets it, and a software write that clears it. The bench provokes this on a rising-edge pin. It raises the pin and then issues the clearing write so that it lands on exactly the third rising clock edge after the pin change, the edge at which the synchronised event reaches the status register. The bit is judged correct only if it is still set afterwards, both on the interrupt output and in a status read. A checker property also requires that any bit that falls was preceded by a write that zeroed it.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
// Two-flop synchroniser; idles high so released pins raise no event.
module eis_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q_o    <= '1;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/eis_detect.sv
// Per-pin condition detector: compares the current sample with the last one.
module eis_detect
  import eis_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   samp_i,
  input  logic [2*W-1:0] sense_i,
  output logic [W-1:0]   prev_o,
  output logic [W-1:0]   event_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= '1;
    else        prev_o <= samp_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    sense_e code;
    assign code = sense_e'(sense_i[2*g +: 2]);
    always_comb begin
      unique case (code)
        SENSE_LOW:  event_o[g] = ~samp_i[g];
        SENSE_FALL: event_o[g] = prev_o[g] & ~samp_i[g];
        SENSE_RISE: event_o[g] = ~prev_o[g] & samp_i[g];
        SENSE_BOTH: event_o[g] = prev_o[g] ^ samp_i[g];
        default:    event_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eis_regs.sv
// Sense-code and status registers with the simple register port.
module eis_regs #(
  parameter int                W          = 8,
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] SENSE_OFS  = 8'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [W-1:0]     event_i,
  output logic [2*W-1:0]   sense_o,
  output logic [W-1:0]     status_o
);
  localparam int SW = 2 * W;

  logic wr_status, wr_sense;
  logic [W-1:0] keep_mask;
  logic unused_wdata_hi;

  assign wr_status = bus_en && bus_we && (bus_addr == STATUS_OFS);
  assign wr_sense  = bus_en && bus_we && (bus_addr == SENSE_OFS);
  assign keep_mask = wr_status ? bus_wdata[W-1:0] : '1;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_o  <= '0;
      status_o <= '0;
    end else begin
      if (wr_sense) sense_o <= bus_wdata[SW-1:0];
      // event wins over a same-cycle clear
      status_o <= (status_o & keep_mask) | event_i;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (bus_addr == STATUS_OFS)     bus_rdata[W-1:0]  = status_o;
      else if (bus_addr == SENSE_OFS) bus_rdata[SW-1:0] = sense_o;
    end
  end
endmodule

// File: rtl/ext_irq_sense_unit.sv
module ext_irq_sense_unit #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int SW = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] pin_now, pin_prev, pin_event, status_q;
  logic [SW-1:0]       sense_q;

  eis_sync #(.W(NUM_PINS)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_now)
  );

  eis_detect #(.W(NUM_PINS)) i_detect (
    .clk(clk), .rst_n(rst_n), .samp_i(pin_now), .sense_i(sense_q),
    .prev_o(pin_prev), .event_o(pin_event)
  );

  eis_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .event_i(pin_event), .sense_o(sense_q), .status_o(status_q)
  );

  assign irq_o = status_q;
endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_PINS-1:0]   irq_o,
  input logic [NUM_PINS-1:0]   pin_now,
  input logic [NUM_PINS-1:0]   pin_prev,
  input logic [2*NUM_PINS-1:0] sense_q
);
  localparam int SW = 2 * NUM_PINS;

  a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr != 8'h10 && bus_addr != 8'h14) |-> bus_rdata == '0);

  a_r2_sense_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 8'h14) |-> bus_rdata[DATA_W-1:SW] == '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o[i]) |-> $past(bus_en && bus_we && bus_addr == 8'h10 && !bus_wdata[i]));

    a_r3_low_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[2*i +: 2] == 2'd0 && !pin_now[i]) |=> irq_o[i]);

    a_r8_rise_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[2*i +: 2] == 2'd2 && pin_now[i] && !pin_prev[i]) |=> irq_o[i]);

    a_r6_both_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[2*i +: 2] == 2'd3 && (pin_now[i] != pin_prev[i])) |=> irq_o[i]);
  end
endmodule

bind ext_irq_sense_unit eis_checker #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_eis_checker (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .pin_now(pin_now), .pin_prev(pin_prev), .sense_q(sense_q)
);

// File: tb/test_ext_irq_sense_unit.sv
module test_ext_irq_sense_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ST = 8'h10;
  localparam logic [7:0] SN = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = 8'hFF;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense_unit i_ext_irq_sense_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clr(input int p);
    wr(ST, ~(32'h1 << p));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {24'h0, irq_o}, 32'h0);
    rd(ST, d); chk("R1 status", d, 32'h0);
    rd(SN, d); chk("R1 sense", d, 32'h0);
  endtask

  task automatic t_sense_cfg();
    logic [31:0] d;
    // pin0 low, pin1 fall, pin2 rise, pin3 both, pins 4..7 rise
    wr(SN, 32'hFFFF_AAE4);
    rd(SN, d); chk("R2 sense readback", d, 32'h0000_AAE4);
    waitn(4);
    chk("R2 no spurious irq", {24'h0, irq_o}, 32'h0);
  endtask

  task automatic t_low_level();
    logic [31:0] d;
    pin_i[0] = 0;
    waitn(2); chk("R11 low not yet", {31'h0, irq_o[0]}, 32'h0);
    waitn(1); chk("R3 low sets", {31'h0, irq_o[0]}, 32'h1);
    rd(ST, d); chk("R9 status matches irq", d, 32'h1);
    clr(0); chk("R3 held while low", {31'h0, irq_o[0]}, 32'h1);
    pin_i[0] = 1; waitn(3);
    chk("R3 still set until cleared", {31'h0, irq_o[0]}, 32'h1);
    clr(0); chk("R3 cleared after high", {31'h0, irq_o[0]}, 32'h0);
  endtask

  task automatic t_falling();
    pin_i[1] = 0;
    waitn(2); chk("R11 fall not yet", {31'h0, irq_o[1]}, 32'h0);
    waitn(1); chk("R4 fall sets", {31'h0, irq_o[1]}, 32'h1);
    clr(1); chk("R7 clear by zero", {31'h0, irq_o[1]}, 32'h0);
    pin_i[1] = 1; waitn(4);
    chk("R4 rise ignored", {31'h0, irq_o[1]}, 32'h0);
  endtask

  task automatic t_rising();
    pin_i[2] = 0; waitn(4);
    chk("R5 fall ignored", {31'h0, irq_o[2]}, 32'h0);
    pin_i[2] = 1; waitn(3);
    chk("R5 rise sets", {31'h0, irq_o[2]}, 32'h1);
    clr(2); chk("R5 cleared", {31'h0, irq_o[2]}, 32'h0);
  endtask

  task automatic t_both();
    pin_i[3] = 0; waitn(3);
    chk("R6 fall sets", {31'h0, irq_o[3]}, 32'h1);
    clr(3); chk("R6 cleared", {31'h0, irq_o[3]}, 32'h0);
    pin_i[3] = 1; waitn(3);
    chk("R6 rise sets", {31'h0, irq_o[3]}, 32'h1);
    clr(3);
  endtask

  task automatic t_write_one();
    logic [31:0] d;
    wr(ST, 32'hFFFF_FFFF);
    rd(ST, d); chk("R7 write one no set", d, 32'h0);
    pin_i[4] = 0; waitn(4); pin_i[4] = 1; waitn(3);
    wr(ST, 32'hFFFF_FFFF);
    rd(ST, d); chk("R7 write one keeps bit", d, 32'h10);
    clr(4);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pin_i[2] = 0; waitn(4);
    pin_i[2] = 1; waitn(2);
    clr(2); // write lands on the third edge, same as the event
    chk("R8 event beats clear irq", {31'h0, irq_o[2]}, 32'h1);
    rd(ST, d); chk("R8 event beats clear status", d, 32'h4);
    clr(2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pin_i[5] = 0; waitn(4); pin_i[5] = 1; waitn(3);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    rd(8'h18, d); chk("R10 unmapped read", d, 32'h0);
    rd(8'h04, d); chk("R10 other unmapped read", d, 32'h0);
    rd(SN, d); chk("R10 sense untouched", d, 32'h0000_AAE4);
    rd(ST, d); chk("R10 status untouched", d, 32'h20);
    clr(5);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sense_cfg();
    t_low_level();
    t_falling();
    t_rising();
    t_both();
    t_write_one();
    t_collision();
    t_unmapped();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule